// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one external interrupt request pin and turns the selected activity on it into a pending flag. The flag can drive an interrupt request to the processor. The pin first passes through a clocked synchronizer. A detector then looks for an active edge, or for an active edge or an active level, depending on the mode. One polarity setting picks both the active edge direction and the active level.

Software controls the block through one 8-bit status/control register. The register holds the pin enable, the pull-device disable, the polarity, the detection mode and the interrupt enable. It also returns the pending flag when read, and writing the acknowledge bit clears the flag. The block drives the pad's pullup and pulldown enables. The polarity setting also decides which of the two is used: a falling-active pin gets a pullup and a rising-active pin gets a pulldown.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset every register bit reads 0, and `irq_o`, `pullup_en_o` and `pulldown_en_o` are all 0.
- R2: Register bit map: bit 6 pull-device disable, bit 5 polarity, bit 4 pin enable, bit 3 pending flag, bit 1 interrupt enable, bit 0 mode (0 = edge only, 1 = edge and level). A write stores bits 6, 5, 4, 1 and 0 and reads them back. Bits 7 and 2 always read 0. Writing bit 3 has no effect on the flag.
- R3: The pin passes through a two-stage synchronizer. An active pin change made between clock edges is seen in the flag after the third rising clock edge, and not after the second.
- R4: In edge-only mode with polarity 0, only a falling edge sets the flag. With polarity 1, only a rising edge sets it. A pin held steady at any level does not set the flag.
- R5: In edge-and-level mode, the pin sitting at the active level (low for polarity 0, high for polarity 1) sets the flag even if no edge has occurred.
- R6: A write with bit 2 set clears the flag. In edge-and-level mode the flag stays set while the synchronized pin is still at the active level, and the next acknowledge after the pin has left that level clears it.
- R7: If an active edge is detected in the same cycle as an acknowledge write, the flag is set after that cycle.
- R8: While the pin enable is 0, no pin activity sets the flag.
- R9: `irq_o` is high exactly when the flag and the interrupt enable are both 1.
- R10: `pullup_en_o` = pin enable AND NOT pull-device disable AND NOT polarity. `pulldown_en_o` = pin enable AND NOT pull-device disable AND polarity. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| pullup_en_o | output | 1 | Enable for the internal pullup |
| pulldown_en_o | output | 1 | Enable for the internal pulldown |

## Verification
The bench builds the block with its default of two synchronizer stages, so the latency from a pin change to the flag is a fixed three clock edges and can be checked to the cycle. With only five stored control bits, the bench sweeps every combination of pull disable, polarity, enable and interrupt enable, and computes the pull outputs and readback for each one. It then runs both polarities through edge-only and edge-and-level sequences. These include an acknowledge while the pin is at the active level and an acknowledge timed to land on the same edge as a fresh detection.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_PDD  = 6;
  localparam int BIT_POL  = 5;
  localparam int BIT_PE   = 4;
  localparam int BIT_FLAG = 3;
  localparam int BIT_ACK  = 2;
  localparam int BIT_IE   = 1;
  localparam int BIT_MODE = 0;

  typedef struct packed {
    logic pdd;
    logic pol;
    logic pe;
    logic ie;
    logic lvl_mode;
  } extirq_cfg_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        smp_i,
  input  extirq_cfg_t cfg_i,
  output logic        event_o,
  output logic        level_act_o
);
  logic prev_q;
  logic rise, fall, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= smp_i;
  end

  assign rise        = smp_i & ~prev_q;
  assign fall        = ~smp_i & prev_q;
  assign edge_hit    = cfg_i.pol ? rise : fall;
  assign level_act_o = (smp_i == cfg_i.pol);
  assign event_o     = cfg_i.pe & (edge_hit | (cfg_i.lvl_mode & level_act_o));

  // edge-only detection needs the sample to have just crossed into the active level
  p_edge_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !cfg_i.lvl_mode) |-> (smp_i == cfg_i.pol) && ($past(smp_i) != cfg_i.pol));
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             event_i,
  input  logic             level_act_i,
  output extirq_cfg_t      cfg_o,
  output logic             flag_o
);
  logic ack;
  logic flag_d;
  logic unused_wbits;

  assign ack          = wr_i & wdata_i[BIT_ACK];
  assign unused_wbits = ^{wdata_i[REG_W-1], wdata_i[BIT_FLAG]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_i) begin
      cfg_o.pdd      <= wdata_i[BIT_PDD];
      cfg_o.pol      <= wdata_i[BIT_POL];
      cfg_o.pe       <= wdata_i[BIT_PE];
      cfg_o.ie       <= wdata_i[BIT_IE];
      cfg_o.lvl_mode <= wdata_i[BIT_MODE];
    end
  end

  // a detection wins over a simultaneous acknowledge
  always_comb begin
    flag_d = flag_o;
    if (ack)     flag_d = 1'b0;
    if (event_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= flag_d;
  end

  p_set_needs_pe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(cfg_o.pe));

  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[BIT_ACK] && !event_i) |=> !flag_o);

  p_level_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && cfg_o.lvl_mode && cfg_o.pe && level_act_i) |=> flag_o);

  p_event_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> flag_o);
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             pullup_en_o,
  output logic             pulldown_en_o
);
  logic        pin_s;
  logic        evt;
  logic        lvl_act;
  logic        flag;
  extirq_cfg_t cfg;
  logic        pull_on;

  extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  extirq_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (pin_s),
    .cfg_i      (cfg),
    .event_o    (evt),
    .level_act_o(lvl_act)
  );

  extirq_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .wdata_i    (reg_wdata_i),
    .event_i    (evt),
    .level_act_i(lvl_act),
    .cfg_o      (cfg),
    .flag_o     (flag)
  );

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[BIT_PDD]  = cfg.pdd;
    reg_rdata_o[BIT_POL]  = cfg.pol;
    reg_rdata_o[BIT_PE]   = cfg.pe;
    reg_rdata_o[BIT_FLAG] = flag;
    reg_rdata_o[BIT_IE]   = cfg.ie;
    reg_rdata_o[BIT_MODE] = cfg.lvl_mode;
  end

  assign irq_o         = flag & cfg.ie;
  assign pull_on       = cfg.pe & ~cfg.pdd;
  assign pullup_en_o   = pull_on & ~cfg.pol;
  assign pulldown_en_o = pull_on & cfg.pol;

  p_pull_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pullup_en_o, pulldown_en_o}));

  p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> reg_rdata_o[BIT_FLAG] && reg_rdata_o[BIT_IE]);
endmodule

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b1;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_o, pullup_en_o, pulldown_en_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  extirq_ctrl u_extirq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .pullup_en_o(pullup_en_o), .pulldown_en_o(pulldown_en_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr_i = 1'b1; reg_wdata_i = v;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
  endtask

  function automatic logic [7:0] cfgv(input logic pdd, input logic pol, input logic pe,
                                      input logic ie, input logic mode);
    return {1'b0, pdd, pol, pe, 1'b0, 1'b0, ie, mode};
  endfunction

  function automatic logic [7:0] flg();
    return {7'd0, reg_rdata_o[3]};
  endfunction

  initial begin
    tick(2);
    chk("R1 rdata", reg_rdata_o, 8'h00);
    chk("R1 outs", {5'd0, irq_o, pullup_en_o, pulldown_en_o}, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    tick(4);
    chk("R1 rdata after release", reg_rdata_o, 8'h00);

    // R2 / R10 / R9: sweep all stored control bits with the pin steady
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      logic pdd, pol, pe, ie;
      {pdd, pol, pe, ie} = i[3:0];
      v = cfgv(pdd, pol, pe, ie, 1'b0);
      wr(v | 8'h88);
      chk("R2 readback", reg_rdata_o, v);
      chk("R10 pullup", {7'd0, pullup_en_o}, {7'd0, pe & ~pdd & ~pol});
      chk("R10 pulldown", {7'd0, pulldown_en_o}, {7'd0, pe & ~pdd & pol});
      chk("R9 irq idle", {7'd0, irq_o}, 8'h00);
    end
    wr(8'h01);
    chk("R2 mode bit", reg_rdata_o, 8'h01);

    // R3 / R4 / R9 / R6: edge-only mode, both polarities
    for (int p = 0; p < 2; p++) begin
      logic pl;
      pl = p[0];
      wr(8'h00);
      pin_i = pl; tick(4);
      wr(cfgv(1'b0, pl, 1'b1, 1'b1, 1'b0));
      tick(4);
      chk("R4 steady active level", flg(), 8'h00);
      pin_i = ~pl; tick(4);
      chk("R4 wrong edge", flg(), 8'h00);
      pin_i = pl; tick(2);
      chk("R3 not after two edges", flg(), 8'h00);
      tick(1);
      chk("R3 R4 set after three edges", flg(), 8'h01);
      chk("R9 irq on", {7'd0, irq_o}, 8'h01);
      wr(cfgv(1'b0, pl, 1'b1, 1'b0, 1'b0));
      chk("R9 irq masked", {7'd0, irq_o}, 8'h00);
      chk("R9 flag kept", flg(), 8'h01);
      wr(cfgv(1'b0, pl, 1'b1, 1'b0, 1'b0) | 8'h08);
      chk("R2 flag write ignored", flg(), 8'h01);
      wr(cfgv(1'b0, pl, 1'b1, 1'b0, 1'b0) | 8'h04);
      chk("R6 ack clears", flg(), 8'h00);
      chk("R2 ack reads 0", reg_rdata_o & 8'h84, 8'h00);
    end

    // R5 / R6: edge-and-level mode, both polarities
    for (int p = 0; p < 2; p++) begin
      logic pl;
      logic [7:0] c;
      pl = p[0];
      c = cfgv(1'b0, pl, 1'b1, 1'b1, 1'b1);
      wr(8'h00);
      pin_i = ~pl; tick(4);
      wr(c); tick(3);
      chk("R5 inactive level", flg(), 8'h00);
      pin_i = pl; tick(3);
      chk("R5 level sets", flg(), 8'h01);
      wr(c | 8'h04);
      chk("R6 ack held by level", flg(), 8'h01);
      tick(1);
      chk("R6 still held", flg(), 8'h01);
      pin_i = ~pl; tick(4);
      chk("R6 flag persists after level", flg(), 8'h01);
      wr(c | 8'h04);
      chk("R6 ack clears after level", flg(), 8'h00);
      // level present before mode switch
      wr(8'h00);
      pin_i = pl; tick(4);
      wr(cfgv(1'b0, pl, 1'b1, 1'b1, 1'b0)); tick(2);
      chk("R4 no edge in edge mode", flg(), 8'h00);
      wr(c);
      chk("R5 before level seen", flg(), 8'h00);
      tick(1);
      chk("R5 level without edge", flg(), 8'h01);
      pin_i = ~pl; tick(4);
      wr(c | 8'h04);
      chk("R6 cleared", flg(), 8'h00);
    end

    // R7: edge and ack on the same clock edge
    wr(8'h00);
    pin_i = 1'b0; tick(4);
    wr(cfgv(1'b0, 1'b1, 1'b1, 1'b1, 1'b0));
    pin_i = 1'b1; tick(3);
    chk("R7 preset", flg(), 8'h01);
    pin_i = 1'b0; tick(4);
    chk("R7 falling ignored", flg(), 8'h01);
    pin_i = 1'b1; tick(2);
    reg_wr_i = 1'b1; reg_wdata_i = cfgv(1'b0, 1'b1, 1'b1, 1'b1, 1'b0) | 8'h04;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
    chk("R7 event beats ack", flg(), 8'h01);
    tick(3);
    wr(cfgv(1'b0, 1'b1, 1'b1, 1'b1, 1'b0) | 8'h04);
    chk("R6 plain ack", flg(), 8'h00);

    // R8: disabled pin never sets the flag
    wr(cfgv(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    for (int k = 0; k < 4; k++) begin
      pin_i = ~pin_i; tick(4);
      chk("R8 disabled pin", flg(), 8'h00);
      chk("R8 irq low", {7'd0, irq_o}, 8'h00);
    end
    chk("R10 disabled pulls", {6'd0, pullup_en_o, pulldown_en_o}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule